// File: doc/BRIEF.md
# Serial Byte-Memory Slave with Zero Write Latency

This block is a serial peripheral slave that sits in front of a byte-wide register array. It behaves like a serial EEPROM, but every write finishes inside the serial transfer, so the host never has to wait for the part to become ready. A host master lowers chip select, sends one command byte, and then, if the command asks for them, two address bytes and any number of data bytes. Read data returns on the output line while the host clocks in dummy bytes.

The serial pins are sampled by the block's own system clock through two-stage synchronisers, and edges are detected internally. The serial clock must therefore run well below the system clock: each serial half period has to span at least four system cycles. The array holds 2^ADDR_W bytes. Set ADDR_W = 13 for the full 8,192-byte organisation. The default build is smaller and keeps the same protocol. Legal ADDR_W values are 9 to 16.

A write-enable latch guards writes. The host sets it with one command and clears it with another. It also clears by itself when a write or a status-write transaction ends.

Top module: `serial_mem_slave`

## Requirements
- R1: A byte written at an address is returned by a later read of that address, and the array holds 2^ADDR_W bytes.
- R2: The address is the two bytes after the command, high byte first. Only the low ADDR_W bits are used, and the bits above them are ignored.
- R3: Data is sampled on rising serial clock edges. The serial clock may idle low or high when chip select falls, and both give the same results.
- R4: The command codes are 0x03 read, 0x02 write, 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status and 0x01 write status. The status byte has bit 1 equal to the write-enable latch and all other bits 0. It repeats for as long as the host keeps clocking.
- R5: Only the first byte after chip select falls is decoded as a command. Set and clear write-enable take no further bytes, and any bytes that follow them in the same selection are not decoded.
- R6: Any unlisted command code is ignored, together with every byte that follows it, until chip select rises.
- R7: The write-enable latch is 0 after reset. A write changes memory only when the latch was set as its command byte completed. The latch clears on the clear command, and again when chip select rises at the end of a write or write-status transaction.
- R8: In a multi-byte read or write, the address steps by one after each data byte and wraps from the top address to 0.
- R9: A data byte commits to memory at its eighth rising edge, with no busy period, and a read in the next selection returns it. A data byte cut short by chip select rising is discarded.
- R10: Read data leaves MSB first and changes after falling serial clock edges. The output enable is 0 while chip select is high and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for miso (a tri-state driver is placed outside the block) |

## Verification
The assertions assume that chip select stays high while rst_n is low. They also assume that every serial clock and chip select level lasts long enough to pass through the synchronisers, so that a rising and a falling serial edge never arrive in the same system cycle. The stimulus meets both assumptions. It holds chip select high through reset, and every serial half period lasts eight system clocks. Mosi changes only with the falling serial edge, so its synchronised copy is stable at each sampling rising edge.

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave #(
  parameter int ADDR_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {PH_OP, PH_AHI, PH_ALO, PH_DATA, PH_SKIP} phase_t;

  logic [2:0] cs_sy, sck_sy;
  logic [1:0] mosi_sy;
  logic [6:0] sr;
  logic [2:0] bitcnt;
  phase_t     phase;
  logic [7:0] op, tx;
  logic [HI_W-1:0]   ahi;
  logic [ADDR_W-1:0] addr;
  logic wel, wr_ok, clr_pend, miso_q;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sy   <= 3'b111;
      sck_sy  <= 3'b000;
      mosi_sy <= 2'b00;
    end else begin
      cs_sy   <= {cs_sy[1:0], cs_n};
      sck_sy  <= {sck_sy[1:0], sck};
      mosi_sy <= {mosi_sy[0], mosi};
    end
  end

  logic cs_act, cs_end, sck_rise, sck_fall, byte_done, is_rd, mem_we;
  logic [7:0] rx_byte, status;
  logic [ADDR_W-1:0] a_new;

  assign cs_act    = ~cs_sy[1];
  assign cs_end    = cs_sy[1] & ~cs_sy[2];
  assign sck_rise  = cs_act & sck_sy[1] & ~sck_sy[2];
  assign sck_fall  = cs_act & ~sck_sy[1] & sck_sy[2];
  assign rx_byte   = {sr, mosi_sy[1]};
  assign byte_done = sck_rise & (bitcnt == 3'd7);
  assign a_new     = {ahi, rx_byte};
  assign status    = {6'b0, wel, 1'b0};
  assign is_rd     = (phase == PH_DATA) && (op == OP_READ || op == OP_RDSR);
  assign mem_we    = byte_done && phase == PH_DATA && op == OP_WRITE && wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; bitcnt <= '0; phase <= PH_OP; op <= '0; tx <= '0;
      ahi <= '0; addr <= '0; wel <= 1'b0; wr_ok <= 1'b0;
      clr_pend <= 1'b0; miso_q <= 1'b0;
    end else if (cs_end) begin
      phase <= PH_OP; bitcnt <= '0; op <= '0; miso_q <= 1'b0;
      wr_ok <= 1'b0; clr_pend <= 1'b0;
      if (clr_pend) wel <= 1'b0;
    end else begin
      if (sck_rise) begin
        sr     <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_OP: begin
            op <= rx_byte;
            case (rx_byte)
              OP_READ:  phase <= PH_AHI;
              OP_WRITE: begin phase <= PH_AHI; wr_ok <= wel; clr_pend <= 1'b1; end
              OP_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
              OP_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
              OP_RDSR:  begin tx <= status; phase <= PH_DATA; end
              OP_WRSR:  begin clr_pend <= 1'b1; phase <= PH_DATA; end
              default:  phase <= PH_SKIP;
            endcase
          end
          PH_AHI: begin
            ahi   <= rx_byte[HI_W-1:0];
            phase <= PH_ALO;
          end
          PH_ALO: begin
            phase <= PH_DATA;
            if (op == OP_READ) begin
              tx   <= mem[a_new];
              addr <= a_new + 1'b1;
            end else begin
              addr <= a_new;
            end
          end
          PH_DATA: begin
            if (op == OP_READ) begin
              tx   <= mem[addr];
              addr <= addr + 1'b1;
            end else if (op == OP_WRITE) begin
              addr <= addr + 1'b1;
            end else if (op == OP_RDSR) begin
              tx <= status;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && is_rd) begin
        miso_q <= tx[7];
        tx     <= {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= rx_byte;
  end

  assign miso    = miso_q;
  assign miso_oe = cs_act;
endmodule

// File: rtl/serial_mem_slave_chk.sv
`timescale 1ns/1ps
module serial_mem_slave_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso_oe,
  input logic              cs_s,
  input logic              cs_end,
  input logic              byte_done,
  input logic [2:0]        phase,
  input logic [7:0]        rx_byte,
  input logic [7:0]        op,
  input logic              wel,
  input logic              wr_ok,
  input logic              clr_pend,
  input logic [ADDR_W-1:0] addr
);
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) && $past(cs_n, 1) |-> !miso_oe); // R10
  AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && phase == 3'd0 && rx_byte == 8'h06 |=> wel); // R4
  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && phase == 3'd0 && rx_byte == 8'h04 |=> !wel); // R7
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end && clr_pend |=> !wel); // R7
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && phase == 3'd0 && rx_byte == 8'h02 && !wel |=> !wr_ok); // R7
  AST_ONE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s && phase != 3'd0 |=> phase != 3'd0); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && phase == 3'd3 && (op == 8'h02 || op == 8'h03)
    |=> addr == ADDR_W'($past(addr) + 1'b1)); // R8
endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
  .cs_s(cs_sy[1]), .cs_end(cs_end), .byte_done(byte_done), .phase(phase),
  .rx_byte(rx_byte), .op(op), .wel(wel), .wr_ok(wr_ok),
  .clr_pend(clr_pend), .addr(addr)
);

// File: tb/serial_mem_slave_tb.sv
`timescale 1ns/1ps
module serial_mem_slave_tb;
  localparam int ADDR_W = 10;
  localparam int HALF   = 8;
  localparam int NV     = 30;
  // ctrl {mode3, kind} | req | addr | data | expected
  // kind: 1 set-WE, 2 clear-WE, 3 write, 4 read, 5 status, 6 raw two bytes (addr field)
  localparam logic [47:0] VEC [NV] = '{
    48'h05_07_0000_00_00, // R7 latch clear after reset
    48'h01_00_0000_00_00,
    48'h05_04_0000_00_02, // R4 status bit 1
    48'h03_00_0010_A5_00,
    48'h05_07_0000_00_00, // R7 cleared by end of write
    48'h04_01_0010_00_A5, // R1
    48'h01_00_0000_00_00,
    48'h03_00_0011_77_00,
    48'h03_00_0011_3C_00,
    48'h04_07_0011_00_77, // R7 write without latch ignored
    48'h01_00_0000_00_00,
    48'h03_00_FC20_5A_00,
    48'h04_02_0020_00_5A, // R2 upper bits ignored
    48'h81_00_0000_00_00,
    48'h83_00_0030_C3_00,
    48'h84_03_0030_00_C3, // R3 idle-high clock
    48'h04_03_0030_00_C3, // R3 idle-low clock
    48'h01_00_0000_00_00,
    48'h02_00_0000_00_00,
    48'h05_07_0000_00_00, // R7 clear command
    48'h06_00_FF06_00_00,
    48'h05_06_0000_00_00, // R6 unknown code then set-WE byte not decoded
    48'h06_00_0604_00_00,
    48'h05_05_0000_00_02, // R5 trailing clear byte not decoded
    48'h02_00_0000_00_00,
    48'h01_00_0000_00_00,
    48'h06_00_0155_00_00,
    48'h05_07_0000_00_00, // R7 cleared by end of status write
    48'h01_00_0000_00_00,
    48'h85_04_0000_00_02  // R4 status in idle-high mode
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  serial_mem_slave #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  always #2.5 clk = ~clk;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic xfer(input bit m3, input int nbits);
    sck = m3; hold(HALF);
    cs_n = 1'b0; hold(HALF);
    for (int k = 0; k < nbits; k++) begin
      sck = 1'b0;
      mosi = txb[k/8][7-(k%8)];
      hold(HALF);
      rxb[k/8][7-(k%8)] = miso;
      sck = 1'b1;
      hold(HALF);
    end
    if (!m3) sck = 1'b0;
    hold(HALF);
    cs_n = 1'b1;
    hold(2*HALF);
  endtask

  task automatic cmd(input bit m3, input logic [7:0] c);
    txb[0] = c; xfer(m3, 8);
  endtask

  task automatic wr1(input bit m3, input logic [15:0] a, input logic [7:0] d);
    txb[0] = 8'h02; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = d;
    xfer(m3, 32);
  endtask

  task automatic rd1(input bit m3, input logic [15:0] a);
    txb[0] = 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = 8'h00;
    xfer(m3, 32);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    hold(4);
    chk(10, {7'b0, miso_oe}, 8'h00); // R10 disabled in reset
    rst_n = 1'b1;
    hold(4);
    cs_n = 1'b0; hold(HALF);
    chk(10, {7'b0, miso_oe}, 8'h01); // R10 enabled while selected
    cs_n = 1'b1; hold(HALF);
    chk(10, {7'b0, miso_oe}, 8'h00); // R10 disabled after deselect

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      case (v[46:40])
        7'd1: cmd(v[47], 8'h06);
        7'd2: cmd(v[47], 8'h04);
        7'd3: wr1(v[47], v[31:16], v[15:8]);
        7'd4: begin rd1(v[47], v[31:16]); chk(int'(v[39:32]), rxb[3], v[7:0]); end
        7'd5: begin
          txb[0] = 8'h05; txb[1] = 8'h00; xfer(v[47], 16);
          chk(int'(v[39:32]), rxb[1], v[7:0]);
        end
        default: begin txb[0] = v[31:24]; txb[1] = v[23:16]; xfer(v[47], 16); end
      endcase
    end

    // R8 sequential write across the top address, then read with wrap
    txb[0] = 8'h02; txb[1] = 8'h03; txb[2] = 8'hFE;
    txb[3] = 8'h11; txb[4] = 8'h22; txb[5] = 8'h33;
    xfer(1'b0, 48);
    txb[0] = 8'h03; txb[1] = 8'h03; txb[2] = 8'hFF; txb[3] = 8'h00; txb[4] = 8'h00;
    xfer(1'b0, 40);
    chk(8, rxb[3], 8'h22);
    chk(8, rxb[4], 8'h33);

    // R4 status repeats while clocking continues
    cmd(1'b0, 8'h06);
    txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
    xfer(1'b0, 24);
    chk(4, rxb[1], 8'h02);
    chk(4, rxb[2], 8'h02);

    // R9 partial data byte is dropped; latch still cleared at end (R7)
    wr1(1'b0, 16'h0040, 8'h12);
    cmd(1'b0, 8'h06);
    txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h40; txb[3] = 8'hFF;
    xfer(1'b0, 28);
    rd1(1'b0, 16'h0040);
    chk(9, rxb[3], 8'h12);
    txb[0] = 8'h05; txb[1] = 8'h00; xfer(1'b0, 16);
    chk(7, rxb[1], 8'h00);

    // R9 committed byte readable in the very next selection
    cmd(1'b0, 8'h06);
    wr1(1'b0, 16'h0041, 8'hE7);
    rd1(1'b0, 16'h0041);
    chk(9, rxb[3], 8'hE7);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule